// File: doc/BRIEF.md
# Sixteen-bit compact integer ALU

This block is the arithmetic and logic stage of a small load/store processor. It combines two 16-bit operands, an incoming carry and a 4-bit operation code into a 16-bit result in the same cycle. A small flag stage captures carry, zero and negative on every clock edge. All four arithmetic operations share one ripple-carry adder-subtractor. The exclusive-OR operation is taken from that adder's operand-inversion stage, so it needs no separate gate array.

Shifts and rotates move the value by exactly one bit position. A multiplexer chooses among three fixed wirings. A carry-gated AND passes operand A only when the incoming carry is set, which lets software build a shift-and-add multiply without a hardware multiplier. The processor also sends branch-target sums (program counter plus offset) through the ADD code. The carry input is normally fed from the carry flag by the surrounding datapath.

Top module: `alu16_core`

## Requirements
- R1: Code 0 (ADD) returns (A + B) mod 2^16, and the carry it produces is bit 16 of the full sum. This code also serves for branch-target sums.
- R2: Code 2 (ADDC) returns (A + B + carry_in) mod 2^16, and the carry it produces is bit 16 of that sum.
- R3: Code 1 (SUB) computes A + ~B + 1 and code 3 (SUBC) computes A + ~B + carry_in. The carry produced is bit 16 of that sum, and 1 means no borrow occurred.
- R4: Code 7 (XOR) returns A ^ B.
- R5: Code 4 (OR) returns A | B, code 5 (AND) returns A & B, and code 6 (NOT) returns ~A.
- R6: Code 8 (ROL) rotates A left through the carry. The result is {A[14:0], carry_in} and the new carry is A[15].
- R7: Code 9 (ROR) rotates A right through the carry. The result is {carry_in, A[15:1]} and the new carry is A[0].
- R8: Code 10 (ASL) returns {A[14:0], 0} and the new carry is A[15].
- R9: Code 11 (ANDC) returns A when carry_in is 1 and zero when carry_in is 0.
- R10: Codes 12 to 15 are unassigned and return a zero result.
- R11: On every rising clock edge, z_flag takes (result == 0) and n_flag takes result bit 15. c_flag takes the produced carry only for codes 0-3 and 8-10, and holds its value for every other code.
- R12: While rst_n is low, all three flags read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag stage |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_sel | input | 4 | Operation code |
| src_a | input | 16 | First operand |
| src_b | input | 16 | Second operand |
| carry_in | input | 1 | Incoming carry |
| alu_out | output | 16 | Combinational result |
| c_flag | output | 1 | Registered carry flag |
| z_flag | output | 1 | Registered zero flag |
| n_flag | output | 1 | Registered negative flag |

## Verification
Carry production and the zero test can land in the same cycle. This happens when an addition wraps to exactly zero, for example 0xFFFF plus 1, or when a subtraction of equal operands gives zero with carry set. The bench provokes this by sweeping every operation code over a grid of corner operands (0, 1, 0x7FFF, 0x8000, 0xFFFF and alternating patterns) with both carry values. It judges both flags after the same edge against its own arithmetic model. A second overlap arises when a logic operation directly follows a carry-producing one. In that case the zero and negative flags change in the same cycle as the carry flag must hold, and the bench's running carry model checks that hold on every vector.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBC = 4'd3,
    OP_OR   = 4'd4,
    OP_AND  = 4'd5,
    OP_NOT  = 4'd6,
    OP_XOR  = 4'd7,
    OP_ROL  = 4'd8,
    OP_ROR  = 4'd9,
    OP_ASL  = 4'd10,
    OP_ANDC = 4'd11
  } alu_op_e;

  // one-bit full adder: returns {carry_out, sum}
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic ci);
    logic s;
    logic co;
    s  = x ^ y ^ ci;
    co = (x & y) | (ci & (x ^ y));
    return {co, s};
  endfunction

  function automatic logic op_sets_carry(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDC) || (op == OP_SUBC) ||
           (op == OP_ROL) || (op == OP_ROR) || (op == OP_ASL);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic [W-1:0] xor_bits
);
  import alu16_pkg::*;

  logic [W-1:0] b_x;
  logic [W:0]   cy;

  // shared inversion stage: also the source of the XOR result
  assign b_x      = b ^ {W{invert_b}};
  assign xor_bits = a ^ b_x;
  assign cy[0]    = cin;

  for (genvar i = 0; i < W; i++) begin : g_ripple
    assign {cy[i+1], sum[i]} = full_add(a[i], b_x[i], cy[i]);
  end

  assign cout = cy[W];
endmodule

// File: rtl/alu_shift1.sv
module alu_shift1 #(
  parameter int W = 16
) (
  input  alu16_pkg::alu_op_e op,
  input  logic [W-1:0]       a,
  input  logic               cin,
  output logic [W-1:0]       res,
  output logic               cout
);
  import alu16_pkg::*;

  always_comb begin
    case (op)
      OP_ROL: begin
        res  = {a[W-2:0], cin};
        cout = a[W-1];
      end
      OP_ROR: begin
        res  = {cin, a[W-1:1]};
        cout = a[0];
      end
      default: begin
        res  = {a[W-2:0], 1'b0};
        cout = a[W-1];
      end
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] res,
  input  logic         c_next,
  input  logic         c_upd,
  output logic         c_q,
  output logic         z_q,
  output logic         n_q
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q     <= 1'b0;
      z_q     <= 1'b0;
      n_q     <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (c_upd) c_q <= c_next;
      z_q     <= (res == '0);
      n_q     <= res[W-1];
      armed_q <= 1'b1;
    end
  end

  assert_zero_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (z_q == ($past(res) == '0)));

  assert_neg_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (n_q == $past(res[W-1])));

  assert_carry_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(c_upd)) |-> (c_q == $past(c_q)));

  assert_reset_clear_R12: assert property (@(posedge clk)
    !rst_n |=> (!c_q && !z_q && !n_q));
endmodule

// File: rtl/alu16_core.sv
module alu16_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_sel,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic         carry_in,
  output logic [W-1:0] alu_out,
  output logic         c_flag,
  output logic         z_flag,
  output logic         n_flag
);
  import alu16_pkg::*;

  alu_op_e      op;
  logic         is_sub;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_co;
  logic [W-1:0] xor_bits;
  logic [W-1:0] sh_res;
  logic         sh_co;
  logic         c_next;
  logic         c_upd;

  assign op     = alu_op_e'(op_sel);
  assign is_sub = (op == OP_SUB) || (op == OP_SUBC);

  always_comb begin
    case (op)
      OP_SUB:           add_cin = 1'b1;
      OP_ADDC, OP_SUBC: add_cin = carry_in;
      default:          add_cin = 1'b0;
    endcase
  end

  alu_addsub #(.W(W)) u_addsub (
    .a        (src_a),
    .b        (src_b),
    .invert_b (is_sub),
    .cin      (add_cin),
    .sum      (add_sum),
    .cout     (add_co),
    .xor_bits (xor_bits)
  );

  alu_shift1 #(.W(W)) u_shift (
    .op   (op),
    .a    (src_a),
    .cin  (carry_in),
    .res  (sh_res),
    .cout (sh_co)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_ADDC, OP_SUBC: alu_out = add_sum;
      OP_OR:                            alu_out = src_a | src_b;
      OP_AND:                           alu_out = src_a & src_b;
      OP_NOT:                           alu_out = ~src_a;
      OP_XOR:                           alu_out = xor_bits;
      OP_ROL, OP_ROR, OP_ASL:           alu_out = sh_res;
      OP_ANDC:                          alu_out = src_a & {W{carry_in}};
      default:                          alu_out = '0;
    endcase
  end

  assign c_upd  = op_sets_carry(op);
  assign c_next = (op == OP_ROL || op == OP_ROR || op == OP_ASL) ? sh_co : add_co;

  alu_flags #(.W(W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .res    (alu_out),
    .c_next (c_next),
    .c_upd  (c_upd),
    .c_q    (c_flag),
    .z_q    (z_flag),
    .n_q    (n_flag)
  );

  assert_xor_share_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XOR) |-> (alu_out == (src_a ^ src_b)));

  assert_no_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB) |-> (add_co == (src_a >= src_b)));

  assert_rol_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROL) |-> ($countones({sh_co, alu_out}) == $countones({src_a, carry_in})));

  assert_ror_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ROR) |-> ($countones({alu_out, sh_co}) == $countones({carry_in, src_a})));

  assert_andc_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ANDC) |-> (alu_out == (carry_in ? src_a : '0)));

  assert_unassigned_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= 4'd12) |-> (alu_out == '0));
endmodule

// File: tb/alu16_core_bench.sv
module alu16_core_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op_sel = '0;
  logic [W-1:0] src_a = '0;
  logic [W-1:0] src_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] alu_out;
  logic         c_flag, z_flag, n_flag;

  int checks = 0;
  int errors = 0;
  logic model_c = 1'b0;

  always #2 clk = ~clk;

  alu16_core #(.W(W)) u_alu16_core (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .src_a(src_a), .src_b(src_b),
    .carry_in(carry_in), .alu_out(alu_out), .c_flag(c_flag), .z_flag(z_flag), .n_flag(n_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h c=%0d actual=%h expected=%h",
               tag, op_sel, src_a, src_b, carry_in, act, exp);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0:  return "R1 add";
      1:  return "R3 sub";
      2:  return "R2 addc";
      3:  return "R3 subc";
      4, 5, 6: return "R5 logic";
      7:  return "R4 xor";
      8:  return "R6 rol";
      9:  return "R7 ror";
      10: return "R8 asl";
      11: return "R9 andc";
      default: return "R10 unassigned";
    endcase
  endfunction

  // expected {carry_updates, carry, result}, computed arithmetically
  function automatic logic [17:0] model(input int op, input int a, input int b, input int c);
    int t;
    case (op)
      0:  begin t = a + b;             return {1'b1, t[16], t[15:0]}; end
      1:  begin t = a + (65535 - b) + 1; return {1'b1, t[16], t[15:0]}; end
      2:  begin t = a + b + c;         return {1'b1, t[16], t[15:0]}; end
      3:  begin t = a + (65535 - b) + c; return {1'b1, t[16], t[15:0]}; end
      4:  begin t = a | b;             return {1'b0, 1'b0, t[15:0]}; end
      5:  begin t = a & b;             return {1'b0, 1'b0, t[15:0]}; end
      6:  begin t = 65535 - a;         return {1'b0, 1'b0, t[15:0]}; end
      7:  begin t = a ^ b;             return {1'b0, 1'b0, t[15:0]}; end
      8:  begin t = (a * 2 + c) % 65536;     return {1'b1, a[15], t[15:0]}; end
      9:  begin t = a / 2 + c * 32768;       return {1'b1, a[0], t[15:0]}; end
      10: begin t = (a * 2) % 65536;         return {1'b1, a[15], t[15:0]}; end
      11: begin t = (c != 0) ? a : 0;        return {1'b0, 1'b0, t[15:0]}; end
      default: return 18'd0;
    endcase
  endfunction

  task automatic apply(input int op, input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [17:0] m;
    @(negedge clk);
    op_sel = op[3:0]; src_a = a; src_b = b; carry_in = c;
    m = model(op, int'(a), int'(b), int'(c));
    #1;
    chk(tag_of(op), {16'd0, alu_out}, {16'd0, m[15:0]});
    @(posedge clk);
    #1;
    if (m[17]) model_c = m[16];
    chk("R11 carry", {31'd0, c_flag}, {31'd0, model_c});
    chk("R11 zero", {31'd0, z_flag}, {31'd0, (m[15:0] == 16'd0)});
    chk("R11 negative", {31'd0, n_flag}, {31'd0, m[15]});
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] corner [8];
    logic [15:0] lfsr;
    corner[0] = 16'h0000; corner[1] = 16'h0001; corner[2] = 16'h7FFF; corner[3] = 16'h8000;
    corner[4] = 16'hFFFF; corner[5] = 16'hAAAA; corner[6] = 16'h5555; corner[7] = 16'h00FF;

    // R12: flags cleared under reset
    src_a = 16'hFFFF; src_b = 16'h0001; op_sel = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset c", {31'd0, c_flag}, 32'd0);
    chk("R12 reset z", {31'd0, z_flag}, 32'd0);
    chk("R12 reset n", {31'd0, n_flag}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // corner grid over every code, both carry values
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int c = 0; c < 2; c++)
            apply(op, corner[i], corner[j], c[0]);

    // R11: logic op right after a carry-producing wrap must hold carry
    apply(0, 16'hFFFF, 16'h0001, 1'b0);
    apply(4, 16'h0000, 16'h0000, 1'b0);
    apply(1, 16'h0000, 16'h0001, 1'b0);
    apply(11, 16'h1234, 16'h0000, 1'b1);

    // pseudo-random sweep
    lfsr = 16'hACE1;
    for (int k = 0; k < 1500; k++) begin
      logic [15:0] ra;
      logic [15:0] rb;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ra = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rb = lfsr;
      apply(k % 16, ra, rb, lfsr[3]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule